// File: doc/BRIEF.md
# External Interrupt Pin Control and Status Register

This block combines one 16-bit control and status word of an interrupt controller with the sensing logic for two external active-low interrupt pins, A and B. Each pin passes through a two-flop synchronizer. Software then chooses whether the pin raises a request while it is held low or once for each falling edge it shows. A falling edge is remembered in a pending latch. The latch is released when the core acknowledges the vector that belongs to that pin. While the system is in stop or wait mode, both pins are sensed by level whatever their select bits say. This lets a pin wake the system without a clock-driven edge detector.

When the core jumps into a new service routine (signalled by `core_ack`), the word records the priority mask and the vector number that the core presents. These two fields change only at that moment, so a nested entry overwrites what an earlier handler has not yet read. The word also shows the synchronized pin levels, an indicator that a request is currently driven to the core, and a global disable bit that blocks both requests. The register is a single location. A write with `reg_wr` updates the writable bits on the next clock edge, and the read value is always present on `reg_rdata`.

Top module: `irq_ctl_reg`

## Requirements
- R1: Bit 15 of `reg_rdata` reads 1 exactly when `irq_a_req` or `irq_b_req` is 1.
- R2: Bits 14:13 hold the `core_prio` value sampled on the last clock edge with `core_ack` high. The encoding is 00 = nested levels 0..3 allowed, 01 = levels 1..3, 10 = levels 2..3, 11 = level 3 only.
- R3: Bits 12:6 hold the `core_vec` value (vector address bits [7:1]) sampled on the last clock edge with `core_ack` high.
- R4: Bits 14:6 change only on an edge where `core_ack` is high. A second acknowledge overwrites the earlier capture.
- R5: Bit 5 is a global disable that resets to 0. While it is 1, both `irq_a_req` and `irq_b_req` are 0.
- R6: Bit 4 always reads 1, and writes to it are ignored.
- R7: Bit 3 shows the level of `pin_b_n` and bit 2 shows the level of `pin_a_n`, each two clock edges after the pin changes.
- R8: Bit 0 selects sensing for pin A and bit 1 for pin B: 0 means low-level and 1 means falling-edge. In level mode the request is 1 while the synchronized pin is low.
- R9: In edge mode, a falling edge sets a pending latch, and the request rises three edges after the pin falls. The request stays 1 after the pin returns high. It clears only on an edge where `core_ack` is high with `core_vec` equal to that pin's vector (VEC_A = 8, VEC_B = 9 by default).
- R10: While `stop_mode` or `wait_mode` is 1, both pins use level sensing regardless of bits 1:0. A pending latch does not drive a request, and a falling edge does not set the latch.
- R11: After reset, bits 5, 1 and 0 and the captured fields read 0. Writes to bits 15 and 14:6 and to bits 3:2 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register value |
| pin_a_n | input | 1 | External interrupt pin A, active low, asynchronous |
| pin_b_n | input | 1 | External interrupt pin B, active low, asynchronous |
| core_ack | input | 1 | Core enters a new service routine |
| core_vec | input | 7 | Vector number being taken |
| core_prio | input | 2 | Priority mask presented on entry |
| stop_mode | input | 1 | Stop mode active |
| wait_mode | input | 1 | Wait mode active |
| irq_a_req | output | 1 | Request to the core from pin A |
| irq_b_req | output | 1 | Request to the core from pin B |

## Verification
The hardest state to reach is a pending edge latch whose request is hidden because low-power mode forces level sensing. There is also the opposite case: an edge arriving during low power, which must leave no trace once the mode ends. The bench configures edge mode, raises `stop_mode`, pulses the pin low and then high, and clears the mode. It then checks that no request appears. In a separate run it acknowledges a vector that does not belong to the pin, and checks that the latch survives until the matching vector arrives.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int CSR_W   = 16;
  localparam int VEC_W   = 7;
  localparam int PRIO_W  = 2;
  localparam int N_PINS  = 2;

  // Level sensing is in force when software picks it or a low-power mode is active.
  function automatic logic eff_level(input logic edge_sel, input logic low_pwr);
    return !edge_sel || low_pwr;
  endfunction

  // Assemble the readable word from its fields.
  function automatic logic [CSR_W-1:0] pack_csr(
    input logic              req_any,
    input logic [PRIO_W-1:0] prio,
    input logic [VEC_W-1:0]  vec,
    input logic              dis,
    input logic [N_PINS-1:0] lvl,
    input logic [N_PINS-1:0] mode
  );
    return {req_any, prio, vec, dis, 1'b1, lvl[1], lvl[0], mode[1], mode[0]};
  endfunction

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_sel,
  input  logic low_pwr,
  input  logic ack_hit,
  output logic lvl,
  output logic fall,
  output logic pend,
  output logic req_raw
);
  import irq_ctl_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl        = sync_q[SYNC_STAGES-1];
  assign fall       = prev_q && !lvl;
  assign level_mode = eff_level(edge_sel, low_pwr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (fall && !level_mode) begin
      pend <= 1'b1;
    end else if (ack_hit) begin
      pend <= 1'b0;
    end
  end

  assign req_raw = level_mode ? !lvl : pend;

endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CSR_W-1:0]  reg_wdata,
  input  logic              core_ack,
  input  logic [VEC_W-1:0]  core_vec,
  input  logic [PRIO_W-1:0] core_prio,
  input  logic [N_PINS-1:0] lvl,
  input  logic              req_any,
  output logic              dis,
  output logic [N_PINS-1:0] mode,
  output logic [CSR_W-1:0]  rdata
);

  logic [PRIO_W-1:0] prio_q;
  logic [VEC_W-1:0]  vec_q;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[15:6], reg_wdata[4:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis  <= 1'b0;
      mode <= '0;
    end else if (reg_wr) begin
      dis  <= reg_wdata[5];
      mode <= reg_wdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      vec_q  <= '0;
    end else if (core_ack) begin
      prio_q <= core_prio;
      vec_q  <= core_vec;
    end
  end

  assign rdata = pack_csr(req_any, prio_q, vec_q, dis, lvl, mode);

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter logic [6:0] VEC_A = 7'd8,
  parameter logic [6:0] VEC_B = 7'd9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        pin_a_n,
  input  logic        pin_b_n,
  input  logic        core_ack,
  input  logic [6:0]  core_vec,
  input  logic [1:0]  core_prio,
  input  logic        stop_mode,
  input  logic        wait_mode,
  output logic        irq_a_req,
  output logic        irq_b_req
);
  import irq_ctl_pkg::*;

  logic [N_PINS-1:0] pins_n, lvl, fall, pend, req_raw, ack_hit, mode;
  logic [VEC_W-1:0]  pin_vec [N_PINS];
  logic              low_pwr, dis, req_any;

  assign pins_n     = {pin_b_n, pin_a_n};
  assign pin_vec[0] = VEC_A;
  assign pin_vec[1] = VEC_B;
  assign low_pwr    = stop_mode || wait_mode;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign ack_hit[i] = core_ack && (core_vec == pin_vec[i]);
    irq_pin_sense #(.SYNC_STAGES(2)) u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (pins_n[i]),
      .edge_sel (mode[i]),
      .low_pwr  (low_pwr),
      .ack_hit  (ack_hit[i]),
      .lvl      (lvl[i]),
      .fall     (fall[i]),
      .pend     (pend[i]),
      .req_raw  (req_raw[i])
    );
  end

  assign irq_a_req = req_raw[0] && !dis;
  assign irq_b_req = req_raw[1] && !dis;
  assign req_any   = irq_a_req || irq_b_req;

  irq_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .core_ack  (core_ack),
    .core_vec  (core_vec),
    .core_prio (core_prio),
    .lvl       (lvl),
    .req_any   (req_any),
    .dis       (dis),
    .mode      (mode),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] reg_rdata,
  input logic        irq_a_req,
  input logic        irq_b_req,
  input logic        core_ack,
  input logic [6:0]  core_vec,
  input logic [1:0]  core_prio,
  input logic        stop_mode,
  input logic        wait_mode
);

  a_r1_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15] == (irq_a_req || irq_b_req));

  a_r2_prio_capture: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> reg_rdata[14:13] == $past(core_prio));

  a_r3_vec_capture: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> reg_rdata[12:6] == $past(core_vec));

  a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ack |=> $stable(reg_rdata[14:6]));

  a_r5_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[5] |-> (!irq_a_req && !irq_b_req));

  a_r6_reserved_one: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4]);

  a_r10_lowpwr_level: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode || wait_mode) |->
      (irq_b_req == (!reg_rdata[3] && !reg_rdata[5])) &&
      (irq_a_req == (!reg_rdata[2] && !reg_rdata[5])));

endmodule

bind irq_ctl_reg irq_ctl_chk u_chk (.*);

// File: tb/sim_irq_ctl_reg.sv
module sim_irq_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_a_n = 1'b1, pin_b_n = 1'b1;
  logic        core_ack = 1'b0;
  logic [6:0]  core_vec = '0;
  logic [1:0]  core_prio = '0;
  logic        stop_mode = 1'b0, wait_mode = 1'b0;
  logic        irq_a_req, irq_b_req;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] VA = 7'd8;
  localparam logic [6:0] VB = 7'd9;

  always #4 clk = ~clk;

  irq_ctl_reg u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic ack(input logic [6:0] v, input logic [1:0] p);
    @(negedge clk); core_ack = 1'b1; core_vec = v; core_prio = p;
    @(negedge clk); core_ack = 1'b0; core_vec = '0; core_prio = '0;
    #1;
  endtask

  task automatic t_reset;
    chk("R11 reset word", reg_rdata, 16'h001C);
    chk("R5 no requests after reset", {14'd0, irq_b_req, irq_a_req}, 16'h0);
  endtask

  task automatic t_readonly;
    wr(16'hFFDC);
    chk("R11 R6 ro bits ignore writes", reg_rdata, 16'h001C);
    wr(16'h0000);
    chk("R6 reserved bit reads 1", {15'd0, reg_rdata[4]}, 16'h1);
  endtask

  task automatic t_level;
    @(negedge clk); pin_a_n = 1'b0;
    cyc(1);
    chk("R7 status not yet after one edge", {15'd0, reg_rdata[2]}, 16'h1);
    cyc(1);
    chk("R7 pin A level after two edges", {15'd0, reg_rdata[2]}, 16'h0);
    chk("R8 level request A", {15'd0, irq_a_req}, 16'h1);
    chk("R1 request flag", {15'd0, reg_rdata[15]}, 16'h1);
    @(negedge clk); pin_a_n = 1'b1; pin_b_n = 1'b0;
    cyc(2);
    chk("R8 level A drops", {15'd0, irq_a_req}, 16'h0);
    chk("R7 pin B level", reg_rdata[3:2], 16'h1);
    chk("R8 level request B", {15'd0, irq_b_req}, 16'h1);
    @(negedge clk); pin_b_n = 1'b1;
    cyc(2);
    chk("R1 flag clears", {15'd0, reg_rdata[15]}, 16'h0);
  endtask

  task automatic t_edge;
    wr(16'h0001);
    chk("R8 mode A bit reads back", reg_rdata[1:0], 16'h1);
    @(negedge clk); pin_a_n = 1'b0;
    cyc(2);
    chk("R9 edge request not before third edge", {15'd0, irq_a_req}, 16'h0);
    cyc(1);
    chk("R9 edge request set", {15'd0, irq_a_req}, 16'h1);
    @(negedge clk); pin_a_n = 1'b1;
    cyc(3);
    chk("R9 pending held after pin high", {15'd0, irq_a_req}, 16'h1);
    ack(VB, 2'd0);
    chk("R9 other vector leaves latch", {15'd0, irq_a_req}, 16'h1);
    ack(VA, 2'd0);
    chk("R9 own vector clears latch", {15'd0, irq_a_req}, 16'h0);
    wr(16'h0000);
  endtask

  task automatic t_lowpower;
    wr(16'h0002);
    @(negedge clk); stop_mode = 1'b1; pin_b_n = 1'b0;
    cyc(2);
    chk("R10 stop forces level on B", {15'd0, irq_b_req}, 16'h1);
    @(negedge clk); pin_b_n = 1'b1;
    cyc(3);
    chk("R10 level B drops in stop", {15'd0, irq_b_req}, 16'h0);
    @(negedge clk); stop_mode = 1'b0;
    cyc(1);
    chk("R10 no latch from low-power edge", {15'd0, irq_b_req}, 16'h0);
    @(negedge clk); pin_b_n = 1'b0;
    cyc(3);
    @(negedge clk); pin_b_n = 1'b1; wait_mode = 1'b1;
    cyc(3);
    chk("R10 pending hidden in wait", {15'd0, irq_b_req}, 16'h0);
    @(negedge clk); wait_mode = 1'b0;
    cyc(1);
    chk("R9 pending returns after wait", {15'd0, irq_b_req}, 16'h1);
    ack(VB, 2'd0);
    chk("R9 B cleared by its vector", {15'd0, irq_b_req}, 16'h0);
    wr(16'h0000);
  endtask

  task automatic t_capture;
    ack(7'h55, 2'b10);
    chk("R2 prio captured", {14'd0, reg_rdata[14:13]}, 16'h2);
    chk("R3 vector captured", {9'd0, reg_rdata[12:6]}, 16'h55);
    cyc(3);
    chk("R4 fields hold without ack", {7'd0, reg_rdata[14:6]}, {7'd0, 2'b10, 7'h55});
    ack(7'h12, 2'b11);
    chk("R4 nested ack overwrites", {7'd0, reg_rdata[14:6]}, {7'd0, 2'b11, 7'h12});
  endtask

  task automatic t_disable;
    wr(16'h0020);
    chk("R5 disable reads back", {15'd0, reg_rdata[5]}, 16'h1);
    @(negedge clk); pin_a_n = 1'b0;
    cyc(2);
    chk("R5 request blocked", {14'd0, irq_b_req, irq_a_req}, 16'h0);
    chk("R1 flag off when blocked", {15'd0, reg_rdata[15]}, 16'h0);
    wr(16'h0000);
    chk("R5 request after enable", {15'd0, irq_a_req}, 16'h1);
    @(negedge clk); pin_a_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_readonly;
    t_level;
    t_edge;
    t_lowpower;
    t_capture;
    t_disable;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule